// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the control decoder of a single-cycle 32-bit core. It is purely combinational and works in two levels. The first level looks only at the 6-bit opcode of the fetched instruction. It produces the datapath strobes: destination select, operand-B select, writeback-source select, register write, memory write, branch, jump and immediate-extension mode. It also produces a compact 3-bit ALU class code. The second level is a small local decoder. It combines that class code with the low bits of the 6-bit function field to form the 3-bit operation code for the ALU.

The decoder covers register-register arithmetic (add, subtract, and, or, set-less-than), or-immediate, word load, word store, branch-if-equal and jump. Strobes that some instructions leave don't-care are driven to 0. For any opcode outside the supported set, every write enable and every flow-change strobe is held low. A bad instruction therefore cannot corrupt architectural state.

Top module: `ctl_decoder_top`

## Requirements
- R1: Opcode 000000 (register-register) asserts regDst and regWrite, clears every other strobe and drives aluOp 100.
- R2: Opcode 001101 (or-immediate) asserts regWrite and aluSrc, keeps extSign 0 (zero-extend), clears the rest and drives aluOp 010.
- R3: Opcode 100011 (load) asserts regWrite, aluSrc, memToReg and extSign (sign-extend), clears the rest and drives aluOp 000.
- R4: Opcode 101011 (store) asserts memWrite, aluSrc and extSign, and drives regWrite, regDst and memToReg to 0, with aluOp 000.
- R5: Opcode 000100 (branch-if-equal) asserts branch only and drives aluOp 001.
- R6: Opcode 000010 (jump) asserts jump only and drives aluOp 000.
- R7: Any other opcode drives all eight strobes to 0 and aluOp to 000.
- R8: Outside register-register mode the function field is ignored. aluOp 000 gives aluCtl 010 (add), 010 gives 001 (or), and 001 gives 110 (subtract).
- R9: In register-register mode, function code 100000 gives aluCtl 010, 100010 gives 110, 100100 gives 000 (and), 100101 gives 001 and 101010 gives 111 (set-less-than).
- R10: In register-register mode, function bits 5 and 4 never change aluCtl. Bit 3 is don't-care for add and for and: 101000 gives 010 and 101100 gives 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| regDst | output | 1 | 1 selects the third register field as destination |
| aluSrc | output | 1 | 1 selects the extended immediate as ALU operand B |
| memToReg | output | 1 | 1 writes memory read data back to the register file |
| regWrite | output | 1 | Register file write enable |
| memWrite | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch on equality |
| jump | output | 1 | Unconditional jump |
| extSign | output | 1 | 1 sign-extends the immediate, 0 zero-extends |
| aluOp | output | 3 | ALU class code passed between decode levels |
| aluCtl | output | 3 | Final ALU operation code |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle the instruction appears. A wrong product term in the first level would raise a write enable on an unsupported opcode, or drop one on a legal one. To catch this, the bench sweeps all 64 opcodes against a behavioural model. A fault in the second level shows up as a wrong ALU code. The bench exercises every legal function code, the variants with bits 5:4 and bit 3 flipped, and function-field noise under non-register opcodes.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int AOP_W  = 3;
  localparam int ACTL_W = 3;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  localparam logic [AOP_W-1:0] AOP_ADD = 3'b000;
  localparam logic [AOP_W-1:0] AOP_SUB = 3'b001;
  localparam logic [AOP_W-1:0] AOP_OR  = 3'b010;
  localparam logic [AOP_W-1:0] AOP_REG = 3'b100;

  typedef struct packed {
    logic              regDst;
    logic              aluSrc;
    logic              memToReg;
    logic              regWrite;
    logic              memWrite;
    logic              branch;
    logic              jump;
    logic              extSign;
    logic [AOP_W-1:0]  aluOp;
  } ctlStrobes_t;
endpackage

// File: rtl/ctl_main_decode.sv
module ctl_main_decode
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctlStrobes_t     strobes
);
  logic isReg, isOri, isLoad, isStore, isBeq, isJump;

  always_comb begin
    isReg   = (opcode == OP_RTYPE);
    isOri   = (opcode == OP_ORI);
    isLoad  = (opcode == OP_LOAD);
    isStore = (opcode == OP_STORE);
    isBeq   = (opcode == OP_BEQ);
    isJump  = (opcode == OP_JUMP);
  end

  always_comb begin
    strobes.regDst   = isReg;
    strobes.aluSrc   = isOri | isLoad | isStore;
    strobes.memToReg = isLoad;
    strobes.regWrite = isReg | isOri | isLoad;
    strobes.memWrite = isStore;
    strobes.branch   = isBeq;
    strobes.jump     = isJump;
    strobes.extSign  = isLoad | isStore;
    strobes.aluOp    = {isReg, isOri, isBeq};
  end

  always_comb begin
    // R4: a store never writes the register file
    a_r4_store_no_regwr: assert (!(strobes.memWrite && strobes.regWrite));
    // R5/R6: at most one state-changing or flow strobe at once
    a_r6_single_effect: assert ($onehot0({strobes.regWrite, strobes.memWrite,
                                          strobes.branch, strobes.jump}));
    // R3: memory writeback implies a register write with an immediate operand
    a_r3_load_path: assert (!strobes.memToReg || (strobes.regWrite && strobes.aluSrc));
    // R2: sign extension is only requested when the immediate is used
    a_r2_ext_needs_imm: assert (!strobes.extSign || strobes.aluSrc);
  end
endmodule

// File: rtl/ctl_alu_decode.sv
module ctl_alu_decode
  import ctl_pkg::*;
(
  input  logic [AOP_W-1:0]  aluOp,
  input  logic [FN_W-1:0]   funct,
  output logic [ACTL_W-1:0] aluCtl
);
  logic regMode;
  logic [3:0] f;

  always_comb begin
    regMode = aluOp[2];
    f       = funct[3:0];
  end

  always_comb begin
    aluCtl[2] = (!regMode & aluOp[0])
              | (regMode & !f[2] & f[1] & !f[0]);
    aluCtl[1] = (!regMode & !aluOp[1])
              | (regMode & !f[2] & !f[0]);
    aluCtl[0] = (!regMode & aluOp[1])
              | (regMode & !f[3] & f[2] & !f[1] & f[0])
              | (regMode & f[3] & !f[2] & f[1] & !f[0]);
  end

  always_comb begin
    // R8: non-register classes only ever pick add, or, subtract
    a_r8_class_ops: assert (regMode || aluCtl == 3'b010 || aluCtl == 3'b001
                            || aluCtl == 3'b110);
    // R9: set-less-than only appears in register mode
    a_r9_slt_reg_only: assert (regMode || aluCtl != 3'b111);
  end
endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
  import ctl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       regDst,
  output logic       aluSrc,
  output logic       memToReg,
  output logic       regWrite,
  output logic       memWrite,
  output logic       branch,
  output logic       jump,
  output logic       extSign,
  output logic [2:0] aluOp,
  output logic [2:0] aluCtl
);
  ctlStrobes_t strobes;

  ctl_main_decode uMain (
    .opcode  (opcode),
    .strobes (strobes)
  );

  ctl_alu_decode uAlu (
    .aluOp  (strobes.aluOp),
    .funct  (funct),
    .aluCtl (aluCtl)
  );

  always_comb begin
    regDst   = strobes.regDst;
    aluSrc   = strobes.aluSrc;
    memToReg = strobes.memToReg;
    regWrite = strobes.regWrite;
    memWrite = strobes.memWrite;
    branch   = strobes.branch;
    jump     = strobes.jump;
    extSign  = strobes.extSign;
    aluOp    = strobes.aluOp;
  end

  always_comb begin
    // R7: any write enable implies a supported opcode
    a_r7_unknown_quiet: assert (!(regWrite || memWrite || branch || jump)
      || opcode inside {6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b000010});
  end
endmodule

// File: tb/sim_ctl_decoder_top.sv
module sim_ctl_decoder_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [5:0] opcode = 6'b111111;
  logic [5:0] funct  = 6'b000000;
  logic regDst, aluSrc, memToReg, regWrite, memWrite, branch, jump, extSign;
  logic [2:0] aluOp, aluCtl;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  ctl_decoder_top u0 (
    .opcode(opcode), .funct(funct), .regDst(regDst), .aluSrc(aluSrc),
    .memToReg(memToReg), .regWrite(regWrite), .memWrite(memWrite),
    .branch(branch), .jump(jump), .extSign(extSign), .aluOp(aluOp), .aluCtl(aluCtl)
  );

  // Behavioural model: {regDst,aluSrc,memToReg,regWrite,memWrite,branch,jump,extSign,aluOp,aluCtl}
  function automatic logic [13:0] model(input logic [5:0] op, input logic [5:0] fn);
    logic [7:0] s;
    logic [2:0] ao;
    logic [2:0] ac;
    s = 8'b0; ao = 3'b000; ac = 3'b010;
    case (op)
      6'b000000: begin
        s = 8'b1001_0000; ao = 3'b100;
        case (fn[3:0])
          4'b0000, 4'b1000: ac = 3'b010;
          4'b0010:          ac = 3'b110;
          4'b0100, 4'b1100: ac = 3'b000;
          4'b0101:          ac = 3'b001;
          4'b1010:          ac = 3'b111;
          default:          ac = 3'bxxx;
        endcase
      end
      6'b001101: begin s = 8'b0101_0000; ao = 3'b010; ac = 3'b001; end
      6'b100011: begin s = 8'b0111_0001; ao = 3'b000; ac = 3'b010; end
      6'b101011: begin s = 8'b0100_1001; ao = 3'b000; ac = 3'b010; end
      6'b000100: begin s = 8'b0000_0100; ao = 3'b001; ac = 3'b110; end
      6'b000010: begin s = 8'b0000_0010; ao = 3'b000; ac = 3'b010; end
      default:   begin s = 8'b0;         ao = 3'b000; ac = 3'b010; end
    endcase
    return {s, ao, ac};
  endfunction

  function automatic string tagFor(input logic [5:0] op);
    case (op)
      6'b000000: return "R1";
      6'b001101: return "R2";
      6'b100011: return "R3";
      6'b101011: return "R4";
      6'b000100: return "R5";
      6'b000010: return "R6";
      default:   return "R7";
    endcase
  endfunction

  task automatic applyCheck(input logic [5:0] op, input logic [5:0] fn, input string tag);
    logic [13:0] got;
    logic [13:0] exp;
    @(posedge clk);
    #1;
    opcode = op;
    funct  = fn;
    @(negedge clk);
    got = {regDst, aluSrc, memToReg, regWrite, memWrite, branch, jump, extSign, aluOp, aluCtl};
    exp = model(op, fn);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, op, fn, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state with an unsupported opcode: R7
    applyCheck(6'b111111, 6'b000000, "R7");
    // opcode sweep: R1..R7 (R8 covered by non-register rows)
    for (int o = 0; o < 64; o++) begin
      applyCheck(6'(o), 6'b100000, tagFor(6'(o)));
    end
    // register-register function codes: R9
    applyCheck(6'b000000, 6'b100000, "R9");
    applyCheck(6'b000000, 6'b100010, "R9");
    applyCheck(6'b000000, 6'b100100, "R9");
    applyCheck(6'b000000, 6'b100101, "R9");
    applyCheck(6'b000000, 6'b101010, "R9");
    // upper bits ignored and bit3 don't-care: R10
    for (int hi = 0; hi < 4; hi++) begin
      applyCheck(6'b000000, {2'(hi), 4'b0000}, "R10");
      applyCheck(6'b000000, {2'(hi), 4'b0010}, "R10");
      applyCheck(6'b000000, {2'(hi), 4'b0100}, "R10");
      applyCheck(6'b000000, {2'(hi), 4'b0101}, "R10");
      applyCheck(6'b000000, {2'(hi), 4'b1010}, "R10");
    end
    applyCheck(6'b000000, 6'b101000, "R10");
    applyCheck(6'b000000, 6'b101100, "R10");
    // funct noise outside register mode: R8
    for (int k = 0; k < 64; k += 7) begin
      applyCheck(6'b100011, 6'(k), "R8");
      applyCheck(6'b001101, 6'(k), "R8");
      applyCheck(6'b000100, 6'(k), "R8");
      applyCheck(6'b101011, 6'(k), "R8");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule